// File: doc/BRIEF.md
# Atomic Swap Lock Unit

This block holds a small array of lock words shared by several requesters. Each requester has its own request port and can issue a read, a plain write or an atomic swap. A swap returns the word's previous contents and stores the requester's value in the same clock edge. No other access can reach that word between the read half and the write half of the swap.

Software builds a spin lock on top of the swap. A requester swaps in 1. If the value returned is 1 the lock was already held, so it retries. If the value returned is 0 it now owns the lock. It releases the lock by writing 0. A lock word of 0 means free and 1 means held.

Only one operation is accepted per grant. The operation is chosen from among simultaneous requests by a round-robin arbiter. Each accepted operation is followed by a single response cycle.

The control is a two-state machine:
- `ST_OPEN` arbitrates among the requests and executes the winning operation at the clock edge.
- `ST_REPLY` presents the response and accepts nothing.

There are two transitions:
- **open→reply** is taken whenever a grant is issued.
- **reply→open** is taken unconditionally after one cycle.

If nothing is requested, the machine stays in `ST_OPEN`.

Top module: `swap_lock_unit`

## Requirements
- R1: After reset every lock word reads 0, and no `req_ready` or `rsp_valid` bit is high while reset is held with no requests.
- R2: Command code 2'b00 (read) returns the addressed word and leaves it unchanged.
- R3: Command code 2'b01 (write) stores the request data into the addressed word and returns the word's previous contents.
- R4: Command code 2'b10 (swap) returns the previous contents and stores the request data in the same edge, so two swaps of 1 to one word in a row return 0 and then 1.
- R5: In any cycle at most one `req_ready` bit is high, and only for a port whose `req_valid` is high.
- R6: Among simultaneous requests, the grant goes to the first requesting port after the most recently granted port, in ascending circular port order; after reset, port 0 has top priority.
- R7: `rsp_valid` is high for exactly the granted port in the cycle after the grant, with `rsp_rdata` carrying the returned value; no grant is issued in that response cycle.
- R8: An ungranted requester that holds its request stalls, and it is granted within 2×PORTS cycles.
- R9: When every port swaps 1 into the same free lock in the same cycle, exactly one of them receives 0.
- R10: Command code 2'b11 behaves as a read: it returns the word and never stores its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | PORTS | Per-port request present |
| req_cmd | input | 2*PORTS | Per-port command code, port p at bits [2p+1:2p] |
| req_addr | input | AW*PORTS | Per-port lock word index |
| req_wdata | input | DW*PORTS | Per-port value for write or swap |
| req_ready | output | PORTS | One-hot grant; request accepted at this edge |
| rsp_valid | output | PORTS | Response pulse for the port granted in the previous cycle |
| rsp_rdata | output | DW | Previous contents of the accessed word |

## Verification
The sharpest corner is the contested lock. All ports swap 1 into one free word together. A design that split the swap into a read cycle and a later write cycle would let two ports see 0 and both enter the critical section. Colliding random traffic on a few addresses exposes three further faults:
- A write that fails to return the old value.
- A 2'b11 command that stores its data.
- An arbiter that favours a fixed port, which starves one requester past the 2×PORTS bound.

The bench also checks the exact grant vector against the circular priority order. This catches a pointer that fails to advance or that skips a port.

// File: rtl/swap_lock_pkg.sv
package swap_lock_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_SWAP  = 2'b10,
        CMD_ALTRD = 2'b11
    } cmd_e;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_REPLY = 1'b1
    } phase_e;
endpackage

// File: rtl/swap_lock_rr_arb.sv
module swap_lock_rr_arb #(
    parameter int PORTS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] req,
    input  logic             advance,
    output logic [PORTS-1:0] grant
);
    localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1;

    logic [PW-1:0] last_q;
    logic [PW-1:0] win_idx;

    // search starts one past the last winner and wraps
    always_comb begin
        grant   = '0;
        win_idx = last_q;
        for (int off = 1; off <= PORTS; off++) begin
            int cand;
            cand = (int'(last_q) + off) % PORTS;
            if (grant == '0 && req[cand]) begin
                grant[cand] = 1'b1;
                win_idx     = PW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= PW'(PORTS - 1);
        end else if (advance && (|grant)) begin
            last_q <= win_idx;
        end
    end
endmodule

// File: rtl/swap_lock_store.sv
module swap_lock_store #(
    parameter int LOCKS = 8,
    parameter int DW    = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] word_q [LOCKS];

    // old value is read combinationally; the new value lands at the same edge
    assign rdata = word_q[addr];

    generate
        for (genvar w = 0; w < LOCKS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[w] <= '0;
                end else if (we && addr == AW'(w)) begin
                    word_q[w] <= wdata;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/swap_lock_unit.sv
module swap_lock_unit
    import swap_lock_pkg::*;
#(
    parameter  int PORTS = 3,
    parameter  int LOCKS = 8,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(LOCKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORTS-1:0]    req_valid,
    input  logic [2*PORTS-1:0]  req_cmd,
    input  logic [AW*PORTS-1:0] req_addr,
    input  logic [DW*PORTS-1:0] req_wdata,
    output logic [PORTS-1:0]    req_ready,
    output logic [PORTS-1:0]    rsp_valid,
    output logic [DW-1:0]       rsp_rdata
);
    phase_e            state_q, state_d;
    logic [PORTS-1:0]  grant;
    logic              fire;
    cmd_e              sel_cmd;
    logic [AW-1:0]     sel_addr;
    logic [DW-1:0]     sel_wdata;
    logic [DW-1:0]     old_word;
    logic              store_we;
    logic [PORTS-1:0]  reply_to_q;
    logic [DW-1:0]     reply_data_q;

    swap_lock_rr_arb #(.PORTS(PORTS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .advance (state_q == ST_OPEN),
        .grant   (grant)
    );

    assign fire = (state_q == ST_OPEN) && (|grant);

    // route the granted port's payload
    always_comb begin
        sel_cmd   = CMD_READ;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (grant[p]) begin
                sel_cmd   = cmd_e'(req_cmd[p*2 +: 2]);
                sel_addr  = req_addr[p*AW +: AW];
                sel_wdata = req_wdata[p*DW +: DW];
            end
        end
    end

    assign store_we = fire && (sel_cmd == CMD_WRITE || sel_cmd == CMD_SWAP);

    swap_lock_store #(.LOCKS(LOCKS), .DW(DW), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (sel_addr),
        .we    (store_we),
        .wdata (sel_wdata),
        .rdata (old_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:  if (fire) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_OPEN;
            default:  state_d = ST_OPEN;
        endcase
    end

    // capture of the returned value at the grant edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_to_q   <= '0;
            reply_data_q <= '0;
        end else if (fire) begin
            reply_to_q   <= grant;
            reply_data_q <= old_word;
        end
    end

    // outputs
    always_comb begin
        req_ready = '0;
        rsp_valid = '0;
        unique case (state_q)
            ST_OPEN:  req_ready = grant;
            ST_REPLY: rsp_valid = reply_to_q;
            default:  ;
        endcase
    end
    assign rsp_rdata = reply_data_q;
endmodule

// File: rtl/swap_lock_checker.sv
module swap_lock_checker #(
    parameter int PORTS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PORTS-1:0] req_valid,
    input logic [PORTS-1:0] req_ready,
    input logic [PORTS-1:0] rsp_valid
);
    p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    p_grant_needs_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    p_rsp_follows_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> (rsp_valid == $past(req_ready)));

    p_no_rsp_without_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> (rsp_valid == '0));

    p_no_grant_in_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |-> (req_ready == '0));
endmodule

bind swap_lock_unit swap_lock_checker #(.PORTS(PORTS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/swap_lock_unit_test.sv
module swap_lock_unit_test;
    localparam int N  = 3;
    localparam int L  = 8;
    localparam int DW = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [N-1:0]    req_valid;
    logic [2*N-1:0]  req_cmd;
    logic [AW*N-1:0] req_addr;
    logic [DW*N-1:0] req_wdata;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    rsp_valid;
    logic [DW-1:0]   rsp_rdata;

    swap_lock_unit #(.PORTS(N), .LOCKS(L), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [DW-1:0] model_mem [L];
    bit            p_val  [N];
    logic [1:0]    p_cmd  [N];
    logic [AW-1:0] p_addr [N];
    logic [DW-1:0] p_data [N];
    int            p_wait [N];
    logic [N-1:0]  last_ready = '0;
    int            rr_last = N - 1;
    logic [N-1:0]  exp_rsp = '0;
    logic [DW-1:0] exp_data = '0;
    string         exp_tag = "R2";
    string         phase = "";
    bit            count_zero = 1'b0;
    int            zero_wins = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] pick(logic [N-1:0] v, int last);
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (last + off) % N;
            if (v[idx]) return N'(1) << idx;
        end
        return '0;
    endfunction

    function automatic string cmd_tag(logic [1:0] c);
        case (c)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic drive_bus();
        for (int p = 0; p < N; p++) begin
            req_valid[p]           = p_val[p];
            req_cmd[p*2 +: 2]      = p_cmd[p];
            req_addr[p*AW +: AW]   = p_addr[p];
            req_wdata[p*DW +: DW]  = p_data[p];
        end
    endtask

    task automatic post(int p, logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d);
        p_val[p] = 1'b1; p_cmd[p] = c; p_addr[p] = a; p_data[p] = d; p_wait[p] = 0;
    endtask

    // one cycle, entered and left at a falling edge
    task automatic step();
        logic [N-1:0] vv, exp_r;
        check(rsp_valid == exp_rsp, "R7", "rsp_valid", rsp_valid, exp_rsp);
        if (|exp_rsp) begin
            check(rsp_rdata == exp_data, exp_tag, "rsp_rdata", rsp_rdata, exp_data);
            if (count_zero && rsp_rdata == '0) zero_wins++;
        end
        for (int p = 0; p < N; p++) if (last_ready[p]) p_val[p] = 1'b0;
        drive_bus();
        #1;
        for (int p = 0; p < N; p++) vv[p] = p_val[p];
        exp_r = (|last_ready) ? '0 : pick(vv, rr_last);
        check(req_ready == exp_r, ($countones(vv) > 1) ? "R6" : "R5", "req_ready",
              req_ready, exp_r);
        exp_rsp = exp_r;
        for (int p = 0; p < N; p++) begin
            if (exp_r[p]) begin
                check(p_wait[p] <= 2 * N, "R8", "wait cycles", p_wait[p], 2 * N);
                exp_data = model_mem[p_addr[p]];
                exp_tag  = (phase != "") ? phase : cmd_tag(p_cmd[p]);
                if (p_cmd[p] == 2'b01 || p_cmd[p] == 2'b10) model_mem[p_addr[p]] = p_data[p];
                rr_last = p;
            end else if (p_val[p]) begin
                p_wait[p]++;
            end
        end
        last_ready = exp_r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        bit busy;
        for (int k = 0; k < 200; k++) begin
            busy = |last_ready;
            for (int p = 0; p < N; p++) busy |= p_val[p];
            if (!busy) break;
            step();
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        for (int w = 0; w < L; w++) model_mem[w] = '0;
        for (int p = 0; p < N; p++) begin
            p_val[p] = 1'b0; p_cmd[p] = '0; p_addr[p] = '0; p_data[p] = '0; p_wait[p] = 0;
        end
        rst_n = 1'b0;
        drive_bus();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == '0, "R1", "rsp_valid in reset", rsp_valid, 0);
        check(req_ready == '0, "R1", "req_ready in reset", req_ready, 0);
        rst_n = 1'b1;

        // R1: every word reads zero after reset
        phase = "R1";
        for (int w = 0; w < L; w++) begin
            post(w % N, 2'b00, AW'(w), 8'hEE);
            drain();
        end
        phase = "";

        // R3 write then R2 read
        post(0, 2'b01, 3'd2, 8'h5A); drain();
        post(1, 2'b00, 3'd2, 8'h00); drain();
        // R10: code 11 returns the word and does not store
        post(2, 2'b11, 3'd2, 8'hFF); drain();
        phase = "R10";
        post(1, 2'b00, 3'd2, 8'h00); drain();
        phase = "";

        // R4: back-to-back swaps of 1
        post(0, 2'b10, 3'd6, 8'h01); drain();
        post(1, 2'b10, 3'd6, 8'h01); drain();
        post(2, 2'b01, 3'd6, 8'h00); drain();

        // R9: all ports contend for a free lock, twice
        for (int round = 0; round < 2; round++) begin
            zero_wins  = 0;
            count_zero = 1'b1;
            for (int p = 0; p < N; p++) post(p, 2'b10, 3'd3, 8'h01);
            drain();
            count_zero = 1'b0;
            check(zero_wins == 1, "R9", "ports seeing free lock", zero_wins, 1);
            post(round % N, 2'b01, 3'd3, 8'h00); drain();
        end

        // random traffic on a few colliding words
        for (int c = 0; c < 800; c++) begin
            for (int p = 0; p < N; p++) begin
                if (!p_val[p] && !last_ready[p] && ($urandom % 2 == 0))
                    post(p, 2'($urandom % 4), AW'($urandom % 4), DW'($urandom % 4));
            end
            step();
        end
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule